// File: doc/BRIEF.md
# Gated and Capture/Compare Timer

This block is a 16-bit up-counter with two modes of operation, selected by a field in its control register. In gated mode the counter advances on each prescale tick while the external timer pin is at its active level. When it reaches the limit register it wraps to 1. An interrupt can be raised on each wrap, on each release of the pin, or on both. In capture/compare mode the counter waits for a first selected edge on the pin. That edge arms it without capturing anything. Each later selected edge copies the running count into a capture register and restarts the count at 1. If no edge comes, the count runs to the limit register, which here acts as the compare value, and then restarts at 1.

The pin is resynchronised through a two-flop chain before any level or edge is interpreted. One interrupt line pulses for one clock per event. A cause flag, also readable in the control register, tells an input event (a capture, or a pin release in gated mode) apart from a limit event. Software programs the block through a small register port: a write strobe with address and data, and a separate read address with a combinational read-back. A count written while the timer is disabled sets the start value of the first pass only.

Top module: `gated_capture_timer`

## Requirements
- R1: After reset, the control word, count, limit and capture registers all read 0, and the interrupt output is low.
- R2: Register addresses are 0 control, 1 count, 2 limit, 3 capture (read only). A write to the count register takes effect only while the enable bit (control bit 0) is 0. While the timer is enabled, such a write is ignored.
- R3: In gated mode (control bit 1 = 0), the count increases by one on each cycle with the tick input high while the synchronised pin is at its active level. The active level is high when control bit 2 is 1 and low when it is 0. The count holds when there is no tick, when the pin is inactive, or when the timer is disabled.
- R4: In gated mode, a counting tick that finds the count equal to the limit sets the count to 1 (a limit event), so the written start value applies only to the first pass.
- R5: In gated mode, a release of the active level is an input event. Control bits 4:3 choose which events interrupt: 00 or 11 both kinds, 01 releases only, 10 limit events only. An input event sets the cause flag, and a limit event that interrupts clears it.
- R6: In capture/compare mode (control bit 1 = 1), the count does not move until the first selected edge. That edge arms the counter, captures nothing and raises no interrupt.
- R7: Each selected edge after arming writes the count into the capture register, sets the count to 1, sets the cause flag and pulses the interrupt.
- R8: In capture/compare mode, an armed counting tick that finds the count equal to the limit sets the count to 1, clears the cause flag and pulses the interrupt.
- R9: When a capture and a compare match fall in the same cycle, the capture wins: one interrupt, the cause flag set, and the capture register loaded with the count.
- R10: Control bit 2 selects the edge used in capture/compare mode: 1 for rising edges, 0 for falling edges. Edges of the other direction have no effect.
- R11: A pin change reaches the interrupt output on the third rising clock edge after it is applied, through two synchroniser flops and one event register.
- R12: The interrupt is a one-cycle pulse per event. The cause flag (output port, and control read-back bit 7) holds its value until the next interrupting event.
- R13: Clearing the enable bit stops the count and discards the armed state, so after re-enabling, the next selected edge arms again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescale tick, one count step per high cycle |
| tmr_pin_i | input | 1 | Asynchronous timer pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address |
| reg_wdata_i | input | 16 | Write data |
| reg_raddr_i | input | 2 | Read address |
| reg_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse |
| irq_src_input_o | output | 1 | Cause flag: 1 input event, 0 limit event |

## Verification
The hardest situation to reach from the ports is a capture edge that arrives in the very cycle the count equals the compare value. In that cycle the priority between the two events is the only thing that decides the outcome. The stimulus arms the counter from a known zero count, then places the next rising edge exactly limit+1 cycles after the arming edge, which allows for the synchroniser delay. This makes the two events land on the same clock edge. A scoreboard then requires exactly one interrupt with the input cause and the limit value captured, and the count read back after a stop shows the restart at 1.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_LIMIT = 2'd2,
        RA_CAPT  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        MODE_GATED  = 1'b0,
        MODE_CAPCMP = 1'b1
    } tmr_mode_e;

    typedef enum logic [1:0] {
        IRQ_ALL        = 2'b00,
        IRQ_GATE_ONLY  = 2'b01,
        IRQ_LIMIT_ONLY = 2'b10,
        IRQ_ALL_ALT    = 2'b11
    } irq_cfg_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        irq_cfg_e  icfg;  // [4:3]
        logic      pol;   // [2]
        tmr_mode_e mode;  // [1]
        logic      en;    // [0]
    } ctrl_t;

    localparam int unsigned CTRL_W    = $bits(ctrl_t);
    localparam int unsigned CAUSE_BIT = 7;

    typedef struct packed {
        logic arm;
        logic capture;
        logic limit;
        logic gate_off;
    } evt_t;

    function automatic logic limit_irq_ok(tmr_mode_e m, irq_cfg_e c);
        return (m == MODE_CAPCMP) || (c != IRQ_GATE_ONLY);
    endfunction

    function automatic logic gate_irq_ok(irq_cfg_e c);
        return c != IRQ_LIMIT_ONLY;
    endfunction

endpackage

// File: rtl/gtm_insync.sv
module gtm_insync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic pol_i,
    output logic active_o,
    output logic accept_o,
    output logic release_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              last_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign active_o  = pol_i ? chain_q[STAGES-1] : ~chain_q[STAGES-1];
    assign last_act  = pol_i ? last_q : ~last_q;
    assign accept_o  = active_o & ~last_act;
    assign release_o = ~active_o & last_act;

    // R11: an accepted edge needs a return to the inactive level first
    p_no_double_edge_r11: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> (!accept_o || (pol_i != $past(pol_i))));

endmodule

// File: rtl/gtm_regs.sv
module gtm_regs
    import gtm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [1:0]       waddr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] limit_o,
    output logic             cnt_wr_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            limit_q <= '0;
        end else if (we_i) begin
            case (waddr_i)
                RA_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
                RA_LIMIT: limit_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    assign ctrl_o   = ctrl_q;
    assign limit_o  = limit_q;
    assign cnt_wr_o = we_i && (waddr_i == RA_COUNT);

    // R2: the limit register changes only through its own address
    p_limit_write_r2: assert property (@(posedge clk) disable iff (rst)
        !(we_i && (waddr_i == RA_LIMIT)) |=> $stable(limit_q));

endmodule

// File: rtl/gtm_core.sv
module gtm_core
    import gtm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             en_i,
    input  tmr_mode_e        mode_i,
    input  irq_cfg_e         icfg_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             active_i,
    input  logic             accept_i,
    input  logic             release_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capt_o,
    output logic             cause_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] capt_q;
    logic             armed_q;
    logic             cause_q;
    logic             irq_q;

    logic gated;
    logic step;
    logic at_limit;
    logic lim_ok;
    logic gate_ok;
    evt_t ev;

    always_comb begin
        gated       = (mode_i == MODE_GATED);
        step        = en_i && tick_i && (gated ? active_i : armed_q);
        at_limit    = (count_q == limit_i);
        ev.arm      = en_i && !gated && !armed_q && accept_i;
        ev.capture  = en_i && !gated && armed_q && accept_i;
        ev.limit    = step && at_limit;
        ev.gate_off = en_i && gated && release_i;
        lim_ok      = limit_irq_ok(mode_i, icfg_i);
        gate_ok     = gate_irq_ok(icfg_i);
    end

    // counter: capture outranks the limit restart
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (!en_i) begin
            if (cnt_wr_i) begin
                count_q <= cnt_wdata_i;
            end
        end else if (ev.capture || ev.limit) begin
            count_q <= RESTART;
        end else if (step) begin
            count_q <= count_q + RESTART;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            capt_q  <= '0;
            cause_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (!en_i) begin
                armed_q <= 1'b0;
            end else if (ev.arm) begin
                armed_q <= 1'b1;
            end
            if (ev.capture) begin
                capt_q <= count_q;
            end
            if (ev.capture || (ev.gate_off && gate_ok)) begin
                cause_q <= 1'b1;
            end else if (ev.limit && lim_ok) begin
                cause_q <= 1'b0;
            end
            irq_q <= ev.capture || (ev.limit && lim_ok) || (ev.gate_off && gate_ok);
        end
    end

    assign count_o = count_q;
    assign capt_o  = capt_q;
    assign cause_o = cause_q;
    assign irq_o   = irq_q;

    // R6: an unarmed capture/compare timer keeps its count
    p_unarmed_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en_i && !gated && !armed_q) |=> $stable(count_q));

    // R7: capture loads the capture register and restarts at 1
    p_capture_load_r7: assert property (@(posedge clk) disable iff (rst)
        ev.capture |=> (count_q == RESTART) && (capt_q == $past(count_q)) && cause_q && irq_q);

    // R8: a compare match without capture restarts the count
    p_compare_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.limit && !ev.capture) |=> (count_q == RESTART));

    // R9: capture wins over a simultaneous compare
    p_capture_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (ev.capture && ev.limit) |=> cause_q);

    // R12: the cause flag moves only on an event
    p_cause_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(ev.capture || ev.limit || ev.gate_off) |=> $stable(cause_q));

    // R3: a disabled timer holds its count unless written
    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !cnt_wr_i) |=> $stable(count_q));

    // R2: a count write while enabled is ignored
    p_locked_write_r2: assert property (@(posedge clk) disable iff (rst)
        (en_i && cnt_wr_i && !step && !ev.capture) |=> $stable(count_q));

endmodule

// File: rtl/gated_capture_timer.sv
module gated_capture_timer
    import gtm_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             tmr_pin_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_waddr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    input  logic [1:0]       reg_raddr_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             irq_src_input_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] limit;
    logic             cnt_wr;
    logic             active;
    logic             accept;
    logic             release_edge;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] capt;
    logic             cause;

    gtm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_i     (reg_we_i),
        .waddr_i  (reg_waddr_i),
        .wdata_i  (reg_wdata_i),
        .ctrl_o   (ctrl),
        .limit_o  (limit),
        .cnt_wr_o (cnt_wr)
    );

    gtm_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (tmr_pin_i),
        .pol_i     (ctrl.pol),
        .active_o  (active),
        .accept_o  (accept),
        .release_o (release_edge)
    );

    gtm_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .en_i        (ctrl.en),
        .mode_i      (ctrl.mode),
        .icfg_i      (ctrl.icfg),
        .limit_i     (limit),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (reg_wdata_i),
        .active_i    (active),
        .accept_i    (accept),
        .release_i   (release_edge),
        .count_o     (count),
        .capt_o      (capt),
        .cause_o     (cause),
        .irq_o       (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_raddr_i)
            RA_CTRL: begin
                reg_rdata_o[CTRL_W-1:0] = ctrl;
                reg_rdata_o[CAUSE_BIT]  = cause;
            end
            RA_COUNT: reg_rdata_o = count;
            RA_LIMIT: reg_rdata_o = limit;
            default:  reg_rdata_o = capt;
        endcase
    end

    assign irq_src_input_o = cause;

endmodule

// File: tb/gated_capture_timer_tb.sv
`timescale 1ns/1ps
module gated_capture_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        pin = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  waddr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [1:0]  raddr = 2'd3;
    logic [15:0] rdata;
    logic        irq;
    logic        src;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        bit          cause;
        bit          has_val;
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    gated_capture_timer u_dut (
        .clk             (clk),
        .rst             (rst),
        .tick_i          (tick),
        .tmr_pin_i       (pin),
        .reg_we_i        (we),
        .reg_waddr_i     (waddr),
        .reg_wdata_i     (wdata),
        .reg_raddr_i     (raddr),
        .reg_rdata_o     (rdata),
        .irq_o           (irq),
        .irq_src_input_o (src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        raddr = a;
        #1;
        d = rdata;
        raddr = 2'd3;
    endtask

    task automatic drive(input logic v, input int gap);
        repeat (gap) @(negedge clk);
        pin = v;
    endtask

    task automatic expect_irq(input bit cause, input bit has_val, input logic [15:0] val, input string req);
        exp_t e;
        e.cause = cause; e.has_val = has_val; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic chk_drained(input string req);
        chk({req, " pending events"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // monitor: pops one expected item per interrupt pulse
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && irq) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected interrupt", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " cause"}, src, e.cause);
                    if (e.has_val) chk({e.req, " capture"}, rdata, e.val);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", irq, 0);
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 count", v, 0);
        rd(2'd2, v); chk("R1 limit", v, 0);
        rd(2'd3, v); chk("R1 capture", v, 0);

        // capture mode, rising edges: arm, then two captures
        wr(2'd1, 16'd0);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, 16'h07);
        drive(1'b1, 3);                       // arming edge, no irq (R6)
        drive(1'b0, 4);
        expect_irq(1'b1, 1'b1, 16'd9, "R7 first capture");
        drive(1'b1, 6);                       // 10 cycles after arming edge
        drive(1'b0, 3);
        expect_irq(1'b1, 1'b1, 16'd12, "R7 second capture");
        drive(1'b1, 9);                       // 12 cycles later
        repeat (8) @(negedge clk);
        chk_drained("R7");
        rd(2'd3, v); chk("R7 capture readback", v, 12);

        // compare mode: two limit wraps, then disable
        wr(2'd0, 16'h06);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd5);
        wr(2'd0, 16'h07);
        drive(1'b0, 2);
        expect_irq(1'b0, 1'b0, 16'd0, "R8 compare 1");
        expect_irq(1'b0, 1'b0, 16'd0, "R8 compare 2");
        drive(1'b1, 3);
        repeat (14) @(negedge clk);
        wr(2'd0, 16'h06);
        repeat (8) @(negedge clk);
        chk_drained("R8");

        // capture and compare in the same cycle
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd7);
        wr(2'd0, 16'h07);
        drive(1'b0, 2);
        drive(1'b1, 3);                       // arm
        drive(1'b0, 3);
        expect_irq(1'b1, 1'b1, 16'd7, "R9 coincident capture");
        drive(1'b1, 5);                       // 8 cycles after arming edge
        repeat (4) @(negedge clk);
        wr(2'd0, 16'h06);
        rd(2'd1, v); chk("R9 restart count", v, 4);
        rd(2'd0, v); chk("R12 cause bit held", v[7], 1);
        chk_drained("R9");

        // re-enable with the pin already high: must wait for a new edge
        wr(2'd0, 16'h07);
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R13 disarmed hold", v, 4);
        wr(2'd0, 16'h06);

        // falling-edge capture
        wr(2'd1, 16'd0);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, 16'h03);
        drive(1'b0, 3);                       // arm on falling edge
        drive(1'b1, 3);                       // rising edge ignored
        expect_irq(1'b1, 1'b1, 16'd6, "R10 falling capture");
        drive(1'b0, 4);
        repeat (8) @(negedge clk);
        chk_drained("R10");
        rd(2'd3, v); chk("R10 capture readback", v, 6);
        wr(2'd0, 16'h02);

        // gated, both interrupt kinds
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h05);
        expect_irq(1'b0, 1'b0, 16'd0, "R4 reload 1");
        expect_irq(1'b0, 1'b0, 16'd0, "R4 reload 2");
        expect_irq(1'b1, 1'b0, 16'd0, "R5 release");
        drive(1'b1, 2);
        drive(1'b0, 8);
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R4 count after passes", v, 2);
        chk_drained("R4");

        // gated, release only; latency and pulse width
        wr(2'd0, 16'h04);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0D);
        expect_irq(1'b1, 1'b0, 16'd0, "R5 release only");
        drive(1'b1, 2);
        drive(1'b0, 8);
        @(negedge clk); chk("R11 irq after 1 edge", irq, 0);
        @(negedge clk); chk("R11 irq after 2 edges", irq, 0);
        @(negedge clk); chk("R11 irq after 3 edges", irq, 1);
        @(negedge clk); chk("R12 pulse width", irq, 0);
        rd(2'd1, v); chk("R5 count", v, 2);
        rd(2'd0, v); chk("R5 cause set", v[7], 1);
        chk_drained("R5a");

        // gated, limit only
        wr(2'd0, 16'h04);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h15);
        expect_irq(1'b0, 1'b0, 16'd0, "R5 limit only 1");
        expect_irq(1'b0, 1'b0, 16'd0, "R5 limit only 2");
        drive(1'b1, 2);
        drive(1'b0, 8);
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R12 cause cleared", v[7], 0);
        chk_drained("R5b");

        // gated without ticks
        tick = 1'b0;
        wr(2'd0, 16'h04);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0D);
        drive(1'b1, 2);
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R3 no tick hold", v, 2);
        expect_irq(1'b1, 1'b0, 16'd0, "R5 release no tick");
        drive(1'b0, 2);
        repeat (5) @(negedge clk);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R3 inactive hold", v, 2);
        chk_drained("R3a");

        // write to count while enabled
        wr(2'd1, 16'h1234);
        rd(2'd1, v); chk("R2 locked write", v, 2);

        // disabled timer ignores the gate
        wr(2'd0, 16'h0C);
        drive(1'b1, 2);
        repeat (6) @(negedge clk);
        rd(2'd1, v); chk("R3 disabled hold", v, 2);
        drive(1'b0, 2);
        repeat (5) @(negedge clk);
        chk_drained("R3b");

        summary();
        $finish;
    end

endmodule